// File: doc/BRIEF.md
# Flash Read-While-Busy Response Controller

This block sits between a bus read port and a flash bank that may be busy with a program or erase operation. When a read arrives and the bank is idle, the read completes at once. When the bank is busy, a 3-bit policy register selects one of three responses:

- end the read at once with an error response;
- stall the read until the bank is idle, with an optional stall interrupt;
- stall the read and ask the flash sequencer to abort its operation, with an optional abort interrupt.

A single-bank strap overrides the policy. With only one bank present, the read cannot run alongside the write, so it always waits.

The read request is a level that the master holds until it sees a one-cycle `rd_ready` or `rd_error` pulse. The abort request and both interrupts are one-cycle pulses, raised in the cycle that follows acceptance of the read. The policy register is written through a plain write strobe. Only the value it holds when a read is accepted applies to that read.

Top module: `flash_rww_ctrl`

## Requirements
- R1: While and right after synchronous reset, all five outputs are low. The policy register holds 3'b111.
- R2: A read sampled at a clock edge with `bank_busy` low gives `rd_ready` high for exactly one cycle after that edge. It raises no error, abort or interrupt, whatever the policy value.
- R3: With `single_bank` low and policy bit 2 equal to 0, a read sampled while `bank_busy` is high gives `rd_error` high for one cycle after that edge. There is no stall, no abort and no interrupt.
- R4: With policy 3'b111, which is also the reset value, a busy read stalls. `rd_ready` pulses one cycle after the first edge that samples `bank_busy` low. No interrupt or abort is raised.
- R5: With policy 3'b110, a busy read stalls and `stall_irq` pulses once, in the cycle after acceptance. No abort is raised.
- R6: With policy 3'b101, a busy read stalls and `abort_req` pulses once, in the cycle after acceptance, however long the bank stays busy. No interrupt is raised.
- R7: With policy 3'b100, a busy read stalls and `abort_req` and `abort_irq` pulse together once, in the cycle after acceptance.
- R8: With `single_bank` high, the policy is ignored. A busy read stalls until the bank is idle, with no error, abort or interrupt.
- R9: A read uses the policy held at its acceptance edge. A write at that same edge, or a write during the stall, applies only to later reads.
- R10: In the cycle in which `rd_ready` or `rd_error` is high, `rd_req` is ignored and all other outputs stay low. A request still held then starts a new read at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request level, held until a response pulse |
| bank_busy | input | 1 | Bank is running a program or erase operation |
| single_bank | input | 1 | Strap: only one bank fitted, policy ignored |
| pol_wr_en | input | 1 | Write strobe for the policy register |
| pol_wr_data | input | 3 | New policy value |
| rd_ready | output | 1 | One-cycle read completion pulse |
| rd_error | output | 1 | One-cycle read error pulse |
| abort_req | output | 1 | One-cycle request to abort the bank operation |
| stall_irq | output | 1 | One-cycle stall notification interrupt |
| abort_irq | output | 1 | One-cycle abort notification interrupt |

## Verification
The hardest situations to reach are the ones where the policy changes around a read.

In the first, a policy write lands on the same edge that accepts a busy read. The bench drives the write strobe and the request together, then checks that the stall follows the old value and that the next read follows the new one.

In the second, a write lands in the middle of a stall. The bench switches the policy to an error-producing value mid-stall and checks that the stalled read still completes normally.

The third is back-to-back reads. The bench holds the request high through the response cycle to confirm that it is ignored there and accepted one edge later.

A behavioural model tracks all of these cases and is compared against every output on every cycle.

// File: rtl/rww_pkg.sv
package rww_pkg;
  localparam int POLICY_W = 3;
  localparam logic [POLICY_W-1:0] POLICY_RESET = {POLICY_W{1'b1}};

  typedef enum logic [2:0] {
    RD_ERROR,
    RD_STALL,
    RD_STALL_IRQ,
    RD_ABORT,
    RD_ABORT_IRQ
  } rd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_STALL,
    SQ_RESP
  } seq_state_e;

  typedef struct packed {
    logic ready;
    logic error;
    logic abort;
    logic stall_irq;
    logic abort_irq;
  } rsp_t;
endpackage

// File: rtl/rww_policy_reg.sv
module rww_policy_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] RESET_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] policy_q
);
  always_ff @(posedge clk) begin
    if (rst) policy_q <= RESET_VAL;
    else if (wr_en) policy_q <= wr_data;
  end
endmodule

// File: rtl/rww_mode_decode.sv
module rww_mode_decode
  import rww_pkg::*;
#(
  parameter int W = POLICY_W
) (
  input  logic [W-1:0] policy,
  input  logic         single_bank,
  output rd_mode_e     mode
);
  // Top policy bit clear selects the error response; the two low bits
  // choose between abort (bit 1 clear) and notification (bit 0 clear).
  always_comb begin
    if (single_bank) begin
      mode = RD_STALL;
    end else if (!policy[W-1]) begin
      mode = RD_ERROR;
    end else begin
      case (policy[1:0])
        2'b11:   mode = RD_STALL;
        2'b10:   mode = RD_STALL_IRQ;
        2'b01:   mode = RD_ABORT;
        default: mode = RD_ABORT_IRQ;
      endcase
    end
  end
endmodule

// File: rtl/rww_seq.sv
module rww_seq
  import rww_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_req,
  input  logic     bank_busy,
  input  rd_mode_e mode,
  output rsp_t     rsp_q
);
  seq_state_e st_q, st_d;
  rsp_t       rsp_d;

  always_comb begin
    st_d  = st_q;
    rsp_d = '0;
    case (st_q)
      SQ_IDLE: begin
        if (rd_req) begin
          if (!bank_busy) begin
            rsp_d.ready = 1'b1;
            st_d        = SQ_RESP;
          end else if (mode == RD_ERROR) begin
            rsp_d.error = 1'b1;
            st_d        = SQ_RESP;
          end else begin
            // mode is consumed only here; the stall ignores later changes
            rsp_d.abort     = (mode == RD_ABORT) || (mode == RD_ABORT_IRQ);
            rsp_d.stall_irq = (mode == RD_STALL_IRQ);
            rsp_d.abort_irq = (mode == RD_ABORT_IRQ);
            st_d            = SQ_STALL;
          end
        end
      end
      SQ_STALL: begin
        if (!bank_busy) begin
          rsp_d.ready = 1'b1;
          st_d        = SQ_RESP;
        end
      end
      default: st_d = SQ_IDLE;  // response cycle: request not sampled
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      rsp_q <= '0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_d;
    end
  end
endmodule

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl
  import rww_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic                bank_busy,
  input  logic                single_bank,
  input  logic                pol_wr_en,
  input  logic [POLICY_W-1:0] pol_wr_data,
  output logic                rd_ready,
  output logic                rd_error,
  output logic                abort_req,
  output logic                stall_irq,
  output logic                abort_irq
);
  logic [POLICY_W-1:0] policy_q;
  rd_mode_e            mode;
  rsp_t                rsp_q;

  rww_policy_reg #(.W(POLICY_W), .RESET_VAL(POLICY_RESET)) i_policy (
    .clk(clk), .rst(rst), .wr_en(pol_wr_en), .wr_data(pol_wr_data),
    .policy_q(policy_q)
  );

  rww_mode_decode #(.W(POLICY_W)) i_decode (
    .policy(policy_q), .single_bank(single_bank), .mode(mode)
  );

  rww_seq i_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .bank_busy(bank_busy),
    .mode(mode), .rsp_q(rsp_q)
  );

  assign rd_ready  = rsp_q.ready;
  assign rd_error  = rsp_q.error;
  assign abort_req = rsp_q.abort;
  assign stall_irq = rsp_q.stall_irq;
  assign abort_irq = rsp_q.abort_irq;
endmodule

// File: rtl/rww_checker.sv
module rww_checker (
  input logic clk,
  input logic rst,
  input logic single_bank,
  input logic rd_ready,
  input logic rd_error,
  input logic abort_req,
  input logic stall_irq,
  input logic abort_irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(rd_ready || rd_error || abort_req || stall_irq || abort_irq));

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  assert_ready_err_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_ready && rd_error));

  assert_stall_irq_no_abort_R5: assert property (@(posedge clk) disable iff (rst)
    stall_irq |-> !abort_req && !abort_irq);

  assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req);

  assert_abort_irq_with_abort_R7: assert property (@(posedge clk) disable iff (rst)
    abort_irq |-> abort_req);

  assert_single_bank_plain_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_error || abort_req || stall_irq || abort_irq) |-> !$past(single_bank));

  assert_resp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_ready || rd_error) |=> !(rd_ready || rd_error || abort_req || stall_irq || abort_irq));
endmodule

bind flash_rww_ctrl rww_checker i_chk (
  .clk(clk), .rst(rst), .single_bank(single_bank),
  .rd_ready(rd_ready), .rd_error(rd_error), .abort_req(abort_req),
  .stall_irq(stall_irq), .abort_irq(abort_irq)
);

// File: tb/test_flash_rww_ctrl.sv
module test_flash_rww_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0, bank_busy = 1'b0, single_bank = 1'b0, pol_wr_en = 1'b0;
  logic [2:0] pol_wr_data = 3'b000;
  logic rd_ready, rd_error, abort_req, stall_irq, abort_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  flash_rww_ctrl i_flash_rww_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req), .bank_busy(bank_busy),
    .single_bank(single_bank), .pol_wr_en(pol_wr_en), .pol_wr_data(pol_wr_data),
    .rd_ready(rd_ready), .rd_error(rd_error), .abort_req(abort_req),
    .stall_irq(stall_irq), .abort_irq(abort_irq)
  );

  // Behavioural reference: pending = a read is waiting on the bank,
  // answered = a response is on the outputs this cycle.
  bit pending = 0, answered = 0;
  logic [2:0] m_pol = 3'b111;
  logic [4:0] exp_o = '0;  // {ready, error, abort, stall_irq, abort_irq}

  always @(posedge clk) begin
    logic [4:0] nx;
    nx = '0;
    if (rst) begin
      pending = 0; answered = 0; m_pol = 3'b111;
    end else begin
      if (answered) begin
        answered = 0;
      end else if (pending) begin
        if (!bank_busy) begin nx[4] = 1; pending = 0; answered = 1; end
      end else if (rd_req) begin
        if (!bank_busy) begin
          nx[4] = 1; answered = 1;
        end else if (!single_bank && m_pol < 4) begin
          nx[3] = 1; answered = 1;
        end else begin
          pending = 1;
          if (!single_bank) begin
            nx[2] = (m_pol == 5) || (m_pol == 4);
            nx[1] = (m_pol == 6);
            nx[0] = (m_pol == 4);
          end
        end
      end
      if (pol_wr_en) m_pol = pol_wr_data;
    end
    exp_o = nx;
  end

  task automatic tick();
    logic [4:0] got;
    @(negedge clk);
    got = {rd_ready, rd_error, abort_req, stall_irq, abort_irq};
    n_cmp++;
    if (got !== exp_o) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", cur_req, got, exp_o, $time);
    end
  endtask

  task automatic set_policy(input logic [2:0] v);
    pol_wr_en = 1; pol_wr_data = v;
    tick();
    pol_wr_en = 0;
  endtask

  task automatic do_read(input int busy_cycles);
    int remaining = busy_cycles;
    bit done = 0;
    rd_req = 1;
    bank_busy = (remaining > 0);
    for (int c = 0; c < 60 && !done; c++) begin
      tick();
      if (rd_ready || rd_error) done = 1;
      if (remaining > 0) remaining--;
      bank_busy = (remaining > 0);
      if (done) rd_req = 0;
    end
    tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst = 0;
    tick();
    // R4 / R1: default policy 111 stalls with no side pulses
    cur_req = "R4";
    do_read(5);
    // R2: idle reads under every policy
    cur_req = "R2";
    for (int p = 0; p < 8; p++) begin
      set_policy(p[2:0]);
      do_read(0);
    end
    // R3: error policies
    cur_req = "R3";
    for (int p = 0; p < 4; p++) begin
      set_policy(p[2:0]);
      do_read(4);
    end
    // R5, R6, R7
    cur_req = "R5"; set_policy(3'b110); do_read(4);
    cur_req = "R6"; set_policy(3'b101); do_read(7);
    cur_req = "R7"; set_policy(3'b100); do_read(3);
    cur_req = "R4"; set_policy(3'b111); do_read(2);
    // R8: single bank ignores policy
    cur_req = "R8";
    single_bank = 1;
    foreach (pol_wr_data[i]) begin end
    set_policy(3'b000); do_read(4);
    set_policy(3'b100); do_read(4);
    set_policy(3'b110); do_read(3);
    single_bank = 0;
    // R9: write during stall does not affect the current read
    cur_req = "R9";
    set_policy(3'b111);
    rd_req = 1; bank_busy = 1;
    tick(); tick();
    pol_wr_en = 1; pol_wr_data = 3'b000;
    tick();
    pol_wr_en = 0;
    tick();
    bank_busy = 0;
    tick(); tick();
    rd_req = 0;
    tick();
    do_read(3);  // later read now sees error policy
    // R9: write on the accepting edge
    set_policy(3'b111);
    rd_req = 1; bank_busy = 1; pol_wr_en = 1; pol_wr_data = 3'b100;
    tick();
    pol_wr_en = 0;
    tick(); tick();
    bank_busy = 0;
    tick(); tick();
    rd_req = 0;
    tick();
    do_read(2);  // abort with interrupt now
    // R10: request held through response cycles
    cur_req = "R10";
    set_policy(3'b011);
    rd_req = 1; bank_busy = 0;
    repeat (6) tick();
    bank_busy = 1;
    repeat (6) tick();
    rd_req = 0;
    repeat (3) tick();
    summary();
    $finish;
  end
endmodule